// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Forwarding

This block gathers up to 32 level-sensitive interrupt requests in front of a primary interrupt controller. Each request is captured in a raw level register on every clock. The captured levels are ANDed with a per-source enable mask, and the results are ORed onto one combined line that feeds one input of the primary controller. A fixed band of sources can also skip the aggregation. For each of those sources a forwarding enable bit connects the captured level straight to the output line with the same index, so the primary controller sees that source on its own input.

Software reaches the block through a word-addressed register port with separate read and write strobes. Enable bits and forwarding bits are changed through set and clear words, so a single write never disturbs bits it does not name. A separate pair of words sets and clears enable bit 0 on any nonzero write, which gives a software-interrupt control. Every output is registered. Status and output lines therefore follow an input change or a register write one clock later. Read data appears in the cycle after the read strobe.

Top module: `sic_aggregator`

## Requirements
- R1: On every clock the raw level register captures `irq_in`, so raw bit i is 1 one clock after input i is high and 0 one clock after it is low.
- R2: Output line 31 is high exactly when (raw level AND enable mask) is nonzero. It follows an input change or an enable write one clock later.
- R3: A read strobe at word address A puts the register value on `rdata` in the next cycle. Word 0 returns raw AND enable, word 1 returns the raw level, and word 2 returns the enable mask.
- R4: A write to word 2 ORs `wdata` into the enable mask. A write to word 3 clears every enable bit that is 1 in `wdata`. All other enable bits keep their values.
- R5: A read of word 4 returns raw bit 0 in bit 0, with zeros above it. A nonzero write to word 4 sets enable bit 0, and a nonzero write to word 5 clears it. A zero write to either word changes nothing.
- R6: A read of word 8 returns the forwarding enable register. A write to word 8 ORs in only bits 21 through 30 of `wdata` (0x7FE00000). A write to word 9 clears the forwarding bits that are 1 in `wdata`.
- R7: For i from 21 to 30, output line i equals raw bit i while forwarding bit i is set, and is low while it is clear. Lines 0 through 20 are always low.
- R8: A read of any word other than 0, 1, 2, 4 or 8 returns zero. A write to any word other than 2, 3, 4, 5, 8 or 9 changes no register. The window is 1024 words.
- R9: A synchronous active-high reset clears the raw level, the enable mask, the forwarding enables, the read data and all output lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Word address (byte offset divided by 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_out | output | 32 | Lines to the primary controller: 31 combined, 21 to 30 forwarded |

## Verification
A corrupted enable bit shows at the ports one clock later: line 31 either stays asserted or fails to assert for a source that is high, and a read of word 2 or word 0 shows the wrong pattern in the following cycle. A stale or out-of-band forwarding bit makes one of lines 21 to 30 follow its input when it should be low, and the same fault makes word 8 read back wrongly. A decode fault on an undefined word shows as nonzero read data or as a changed enable or forwarding value on the next legal read. The stimulus is arranged so that each of these effects is sampled within one or two clocks of the write or input change that would expose it.

// File: rtl/sic_pkg.sv
`timescale 1ns/1ps
package sic_pkg;
    // Word indices within the register window (byte offset >> 2)
    localparam int unsigned WD_STATUS   = 0;
    localparam int unsigned WD_RAW      = 1;
    localparam int unsigned WD_EN_SET   = 2;
    localparam int unsigned WD_EN_CLR   = 3;
    localparam int unsigned WD_SOFT_SET = 4;
    localparam int unsigned WD_SOFT_CLR = 5;
    localparam int unsigned WD_FWD_SET  = 8;
    localparam int unsigned WD_FWD_CLR  = 9;
endpackage

// File: rtl/sic_wr_decode.sv
`timescale 1ns/1ps
module sic_wr_decode
    import sic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned WADDR_W = 10,
    parameter logic [NUM_SRC-1:0] FWD_BAND = '0
) (
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] addr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] fwd_q,
    output logic [NUM_SRC-1:0] en_d,
    output logic [NUM_SRC-1:0] fwd_d
);
    logic nonzero;
    assign nonzero = |wdata;

    always_comb begin
        en_d  = en_q;
        fwd_d = fwd_q;
        if (wr_en) begin
            case (addr)
                WADDR_W'(WD_EN_SET):   en_d = en_q | wdata;
                WADDR_W'(WD_EN_CLR):   en_d = en_q & ~wdata;
                WADDR_W'(WD_SOFT_SET): if (nonzero) en_d[0] = 1'b1;
                WADDR_W'(WD_SOFT_CLR): if (nonzero) en_d[0] = 1'b0;
                WADDR_W'(WD_FWD_SET):  fwd_d = fwd_q | (wdata & FWD_BAND);
                WADDR_W'(WD_FWD_CLR):  fwd_d = fwd_q & ~wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sic_rd_mux.sv
`timescale 1ns/1ps
module sic_rd_mux
    import sic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned WADDR_W = 10
) (
    input  logic [WADDR_W-1:0] addr,
    input  logic [NUM_SRC-1:0] raw_q,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] fwd_q,
    output logic [NUM_SRC-1:0] rd_word
);
    always_comb begin
        rd_word = '0;
        case (addr)
            WADDR_W'(WD_STATUS):   rd_word = raw_q & en_q;
            WADDR_W'(WD_RAW):      rd_word = raw_q;
            WADDR_W'(WD_EN_SET):   rd_word = en_q;
            WADDR_W'(WD_SOFT_SET): rd_word = {{(NUM_SRC-1){1'b0}}, raw_q[0]};
            WADDR_W'(WD_FWD_SET):  rd_word = fwd_q;
            default:               rd_word = '0;
        endcase
    end
endmodule

// File: rtl/sic_line_map.sv
`timescale 1ns/1ps
module sic_line_map #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned AGG_LINE = 31,
    parameter logic [NUM_SRC-1:0] FWD_BAND = '0
) (
    input  logic [NUM_SRC-1:0] raw_d,
    input  logic [NUM_SRC-1:0] en_d,
    input  logic [NUM_SRC-1:0] fwd_d,
    output logic [NUM_SRC-1:0] line_d
);
    logic agg;
    assign agg = |(raw_d & en_d);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        assign line_d[i] = (i == AGG_LINE) ? agg
                         : (FWD_BAND[i] & fwd_d[i] & raw_d[i]);
    end
endmodule

// File: rtl/sic_aggregator.sv
`timescale 1ns/1ps
module sic_aggregator #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned AGG_LINE = 31,
    parameter int unsigned FWD_LO   = 21,
    parameter int unsigned FWD_HI   = 30,
    parameter int unsigned WADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [WADDR_W-1:0] addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    output logic [NUM_SRC-1:0] irq_out
);
    function automatic logic [NUM_SRC-1:0] band_of(input int unsigned lo, input int unsigned hi);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NUM_SRC-1:0] FWD_BAND = band_of(FWD_LO, FWD_HI);

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] fwd;
        logic [NUM_SRC-1:0] line;
        logic [NUM_SRC-1:0] rdat;
    } sic_state_t;

    sic_state_t st_d, st_q;

    logic [NUM_SRC-1:0] raw_q, en_q, fwd_q;
    logic [NUM_SRC-1:0] en_nx, fwd_nx, line_nx, rd_word;

    assign raw_q = st_q.raw;
    assign en_q  = st_q.en;
    assign fwd_q = st_q.fwd;

    sic_wr_decode #(
        .NUM_SRC (NUM_SRC),
        .WADDR_W (WADDR_W),
        .FWD_BAND(FWD_BAND)
    ) wr_dec_i (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .en_q  (en_q),
        .fwd_q (fwd_q),
        .en_d  (en_nx),
        .fwd_d (fwd_nx)
    );

    sic_rd_mux #(
        .NUM_SRC (NUM_SRC),
        .WADDR_W (WADDR_W)
    ) rd_mux_i (
        .addr    (addr),
        .raw_q   (raw_q),
        .en_q    (en_q),
        .fwd_q   (fwd_q),
        .rd_word (rd_word)
    );

    sic_line_map #(
        .NUM_SRC  (NUM_SRC),
        .AGG_LINE (AGG_LINE),
        .FWD_BAND (FWD_BAND)
    ) line_map_i (
        .raw_d  (irq_in),
        .en_d   (en_nx),
        .fwd_d  (fwd_nx),
        .line_d (line_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.raw  = irq_in;
        st_d.en   = en_nx;
        st_d.fwd  = fwd_nx;
        st_d.line = line_nx;
        st_d.rdat = rd_en ? rd_word : st_q.rdat;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata   = st_q.rdat;
    assign irq_out = st_q.line;
endmodule

// File: rtl/sic_aggregator_chk.sv
`timescale 1ns/1ps
module sic_aggregator_chk #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned AGG_LINE = 31,
    parameter int unsigned WADDR_W  = 10,
    parameter logic [NUM_SRC-1:0] FWD_BAND = '0
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_in,
    input logic               wr_en,
    input logic               rd_en,
    input logic [WADDR_W-1:0] addr,
    input logic [NUM_SRC-1:0] wdata,
    input logic [NUM_SRC-1:0] rdata,
    input logic [NUM_SRC-1:0] irq_out,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] fwd_q
);
    localparam logic [NUM_SRC-1:0] AGG_BIT = NUM_SRC'(1) << AGG_LINE;

    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    logic undef_word;
    always_comb begin
        case (addr)
            WADDR_W'(0), WADDR_W'(1), WADDR_W'(2), WADDR_W'(4), WADDR_W'(8): undef_word = 1'b0;
            default: undef_word = 1'b1;
        endcase
    end

    p_raw_follow_r1: assert property (@(posedge clk) disable iff (rst)
        live |-> raw_q == $past(irq_in));

    p_agg_line_r2: assert property (@(posedge clk) disable iff (rst)
        irq_out[AGG_LINE] == |(raw_q & en_q));

    p_raw_read_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == WADDR_W'(1)) |=> rdata == $past(raw_q));

    p_en_set_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == WADDR_W'(2)) |=> (en_q & $past(wdata)) == $past(wdata));

    p_en_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == WADDR_W'(3)) |=> (en_q & $past(wdata)) == '0);

    p_fwd_in_band_r6: assert property (@(posedge clk) disable iff (rst)
        (fwd_q & ~FWD_BAND) == '0);

    p_fwd_lines_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_out & FWD_BAND) == (raw_q & fwd_q & FWD_BAND));

    p_quiet_lines_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_out & ~FWD_BAND & ~AGG_BIT) == '0);

    p_undef_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && undef_word) |=> rdata == '0);
endmodule

bind sic_aggregator sic_aggregator_chk #(
    .NUM_SRC  (NUM_SRC),
    .AGG_LINE (AGG_LINE),
    .WADDR_W  (WADDR_W),
    .FWD_BAND (FWD_BAND)
) chk_i (.*);

// File: tb/sic_aggregator_tb_top.sv
`timescale 1ns/1ps
module sic_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_raw = '0, m_en = '0, m_fwd = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    sic_aggregator dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_lines();
        logic [31:0] o;
        o = m_raw & m_fwd & 32'h7FE0_0000;
        o[31] = |(m_raw & m_en);
        return o;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0: return m_raw & m_en;
            1: return m_raw;
            2: return m_en;
            4: return {31'd0, m_raw[0]};
            8: return m_fwd;
            default: return 32'd0;
        endcase
    endfunction

    // Monitor: read data is valid at the negedge after the capturing posedge
    always @(posedge clk) rd_seen <= rd_en && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL read: unexpected data actual=%h expected=none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    task automatic do_wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = 10'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2: m_en = m_en | d;
            3: m_en = m_en & ~d;
            4: if (d != 0) m_en[0] = 1'b1;
            5: if (d != 0) m_en[0] = 1'b0;
            8: m_fwd = m_fwd | (d & 32'h7FE0_0000);
            9: m_fwd = m_fwd & ~d;
            default: ;
        endcase
    endtask

    task automatic do_rd(input int a, input string tag);
        exp_q.push_back(exp_read(a));
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = 10'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_in(input logic [31:0] v);
        irq_in = v;
        @(negedge clk);
        m_raw = v;
    endtask

    task automatic chk_lines(input string tag);
        logic [31:0] e;
        e = exp_lines();
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s: irq_out actual=%h expected=%h", tag, irq_out, e);
        end
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk_lines("R9");
        do_rd(1, "R9"); do_rd(2, "R9"); do_rd(8, "R9"); do_rd(0, "R9");

        // R1 / R2: raw capture, mask closed
        set_in(32'h0000_0018);
        chk_lines("R2");
        do_rd(1, "R1");
        do_wr(2, 32'h0000_0010);
        chk_lines("R2");
        do_rd(0, "R3"); do_rd(2, "R3");
        set_in(32'h0000_0008);
        chk_lines("R2");
        set_in(32'h0000_0018);
        // R4: set/clear semantics
        do_wr(3, 32'h0000_0010);
        chk_lines("R4");
        do_wr(2, 32'h0000_000F);
        do_wr(3, 32'h0000_0005);
        do_rd(2, "R4");
        chk_lines("R4");

        // R5: software-interrupt word
        set_in(32'h0000_0001);
        do_rd(4, "R5");
        chk_lines("R5");
        do_wr(4, 32'h0);
        do_rd(2, "R5");
        chk_lines("R5");
        do_wr(4, 32'h0000_0080);
        chk_lines("R5");
        do_rd(2, "R5");
        do_wr(5, 32'h0);
        do_rd(2, "R5");
        do_wr(5, 32'h0000_0007);
        chk_lines("R5");
        do_rd(2, "R5");

        // R6 / R7: forwarding band
        do_wr(8, 32'hFFFF_FFFF);
        do_rd(8, "R6");
        chk_lines("R7");
        set_in(32'hFFFF_FFFF);
        chk_lines("R7");
        do_wr(9, 32'h0060_0000);
        do_rd(8, "R6");
        chk_lines("R7");
        set_in(32'h2AA0_0555);
        chk_lines("R7");
        set_in(32'h5540_0AAA);
        chk_lines("R7");
        do_wr(9, 32'hFFFF_FFFF);
        chk_lines("R7");
        do_wr(8, 32'h0020_0001);
        do_rd(8, "R6");
        set_in(32'h0020_0000);
        chk_lines("R7");

        // R8: undefined words
        do_wr(6, 32'hFFFF_FFFF);
        do_wr(7, 32'hFFFF_FFFF);
        do_wr(10'h3FF, 32'hFFFF_FFFF);
        do_rd(2, "R8"); do_rd(8, "R8");
        do_rd(3, "R8"); do_rd(5, "R8"); do_rd(6, "R8"); do_rd(9, "R8"); do_rd(10'h3FF, "R8");
        chk_lines("R8");

        // R9: reset mid-run clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_raw = '0; m_en = '0; m_fwd = '0;
        irq_in = '0;
        @(negedge clk);
        chk_lines("R9");
        do_rd(2, "R9"); do_rd(8, "R9");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule